// File: doc/BRIEF.md
# Bit-Stuffing Tributary Synchronizer

This block moves several low-rate serial tributaries, each written on its own recovered clock, into the single frame-generation clock of a higher-order multiplexer. Every tributary owns a one-bit-wide, sixteen-entry elastic buffer. The write side stores one bit per enabled tributary clock edge. The read side belongs to the frame generator, which pulls bits either with a plain read strobe or at a stuffing opportunity.

At each stuffing opportunity the buffer's occupancy decides the outcome. A low buffer asks the multiplexer to send a stuff bit and leaves the buffer alone. A buffer at or above half depth hands over a data bit. Small frequency offsets and a few unit intervals of jitter on a tributary therefore show up only as a varying stuff rate, and never as lost bits.

The write pointer crosses into the frame clock domain in Gray code through two flops, and the read pointer crosses back the same way. After reset, a lane hands out no data until its occupancy first reaches half depth. Overflow and underflow are flagged and kept until reset, and either one re-centres the lane to half depth.

Top module: `tsync_fifo`

## Requirements
- R1: Each lane delivers its data bits on `dout` (marked by `dout_vld`) in exactly the order they were written.
- R2: A `stuff_opp` pulse on a lane whose occupancy is below 8 gives `stuff_req`=1 (1 means insert a stuff bit) and `dout_vld`=0 on the next frame clock cycle, and consumes nothing. With occupancy 8 or more, the next cycle gives `stuff_req`=0 and `dout_vld`=1 with the oldest bit.
- R3: After reset, `rd_en` is ignored (`dout_vld` stays 0) on a lane until its occupancy first reaches 8. Stuffing opportunities before that point return `stuff_req`=1.
- R4: A `rd_en` on a primed lane with occupancy 0 gives `dout_vld`=0 and sets `udf_flag` on the next cycle, and re-centres the lane to occupancy 8.
- R5: When a lane's occupancy reaches 16, `ovf_flag` is set and the lane drops its oldest 8 bits, keeping the newest 8. A write into a full lane is discarded.
- R6: Lanes are independent: stimulus on one lane changes no output of another.
- R7: A tributary written slightly slower than the frame side's maximum read rate runs without setting either flag, and the frame side issues stuff requests from time to time.
- R8: After reset, `stuff_req`, `dout`, `dout_vld`, `ovf_flag` and `udf_flag` are all 0.
- R9: `ovf_flag` and `udf_flag` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| trib_clk | input | NUM_TRIB | Recovered clock of each tributary |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| trib_en | input | NUM_TRIB | Write enable per tributary, sampled on its own clock |
| trib_bit | input | NUM_TRIB | Tributary data bit per lane |
| frm_clk | input | 1 | Frame-generation clock |
| stuff_opp | input | NUM_TRIB | Stuffing opportunity strobe per lane |
| rd_en | input | NUM_TRIB | Plain data-bit read strobe per lane |
| stuff_req | output | NUM_TRIB | 1 = insert stuff bit at the opportunity just taken |
| dout | output | NUM_TRIB | Data bit read out (0 when not valid) |
| dout_vld | output | NUM_TRIB | Data bit on `dout` is valid |
| ovf_flag | output | NUM_TRIB | Sticky overflow flag |
| udf_flag | output | NUM_TRIB | Sticky underflow flag |

## Verification
A corrupt read pointer or a broken write pointer crossing shows up at the ports within one frame clock cycle of the next strobe. The bit on `dout` is then out of order, or `stuff_req` contradicts the fill that the bench can count from its own writes. A wrong priming or re-centring state shows the same way: at the first opportunity after the event, the stuff decision differs from the expected occupancy of 8. A sticky flag that clears, or that is raised on an untouched lane, is visible on the very next cycle.

// File: rtl/tsync_pkg.sv
`timescale 1ns/1ps
package tsync_pkg;
    // Action taken by a lane's read side in one frame clock cycle
    typedef enum logic [1:0] {
        RD_IDLE     = 2'd0,
        RD_TAKE     = 2'd1,
        RD_STUFF    = 2'd2,
        RD_RECENTRE = 2'd3
    } rd_act_e;
endpackage

// File: rtl/tsync_gray_sync.sv
`timescale 1ns/1ps
module tsync_gray_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = gray_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Gray to binary on the synchronized value
    always_comb begin
        bin_o[W-1] = st_q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ st_q.s2[i];
        end
    end
endmodule

// File: rtl/tsync_wr.sv
`timescale 1ns/1ps
module tsync_wr #(
    parameter int unsigned AW = 4
) (
    input  logic                wclk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                wd,
    input  logic [AW:0]         rd_gray_i,
    output logic [AW:0]         wr_gray_o,
    output logic [(1<<AW)-1:0]  mem_o
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic [DEPTH-1:0] mem;
    } wst_t;

    wst_t        st_d, st_q;
    logic [PW-1:0] rd_bin;
    logic [PW-1:0] fill;

    tsync_gray_sync #(.W(PW)) rd_sync_i (
        .clk    (wclk),
        .rst_n  (rst_n),
        .gray_i (rd_gray_i),
        .bin_o  (rd_bin)
    );

    assign fill = st_q.bin - rd_bin;

    always_comb begin
        st_d = st_q;
        if (we && (fill != FULL_LVL)) begin
            st_d.mem[st_q.bin[AW-1:0]] = wd;
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_gray_o = st_q.gray;
    assign mem_o     = st_q.mem;
endmodule

// File: rtl/tsync_rd.sv
`timescale 1ns/1ps
module tsync_rd
    import tsync_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic               rclk,
    input  logic               rst_n,
    input  logic               stuff_opp,
    input  logic               rd_en,
    input  logic [AW:0]        wr_gray_i,
    input  logic [(1<<AW)-1:0] mem_i,
    output logic [AW:0]        rd_gray_o,
    output logic               stuff_o,
    output logic               dout_o,
    output logic               vld_o,
    output logic               ovf_o,
    output logic               udf_o,
    output logic [AW:0]        occ_o
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          primed;
        logic          stuff;
        logic          dout;
        logic          vld;
        logic          ovf;
        logic          udf;
    } rst_t;

    rst_t          st_d, st_q;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] occ;
    logic          primed_eff;
    rd_act_e       act;
    logic          ovf_ev, udf_ev;

    tsync_gray_sync #(.W(PW)) wr_sync_i (
        .clk    (rclk),
        .rst_n  (rst_n),
        .gray_i (wr_gray_i),
        .bin_o  (wr_bin)
    );

    assign occ        = wr_bin - st_q.bin;
    assign primed_eff = st_q.primed | (occ >= HALF_LVL);

    // Decide this cycle's action; overflow recovery has top priority
    always_comb begin
        act    = RD_IDLE;
        ovf_ev = 1'b0;
        udf_ev = 1'b0;
        if (occ == FULL_LVL) begin
            act    = RD_RECENTRE;
            ovf_ev = 1'b1;
        end else if (stuff_opp) begin
            act = (occ < HALF_LVL) ? RD_STUFF : RD_TAKE;
        end else if (rd_en && primed_eff) begin
            if (occ == '0) begin
                act    = RD_RECENTRE;
                udf_ev = 1'b1;
            end else begin
                act = RD_TAKE;
            end
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.stuff  = 1'b0;
        st_d.vld    = 1'b0;
        st_d.dout   = 1'b0;
        st_d.primed = primed_eff;
        unique case (act)
            RD_TAKE: begin
                st_d.dout = mem_i[st_q.bin[AW-1:0]];
                st_d.vld  = 1'b1;
                st_d.bin  = st_q.bin + 1'b1;
            end
            RD_STUFF:    st_d.stuff = 1'b1;
            RD_RECENTRE: st_d.bin   = wr_bin - HALF_LVL;
            default: ;
        endcase
        st_d.ovf  = st_q.ovf | ovf_ev;
        st_d.udf  = st_q.udf | udf_ev;
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_gray_o = st_q.gray;
    assign stuff_o   = st_q.stuff;
    assign dout_o    = st_q.dout;
    assign vld_o     = st_q.vld;
    assign ovf_o     = st_q.ovf;
    assign udf_o     = st_q.udf;
    assign occ_o     = occ;
endmodule

// File: rtl/tsync_fifo.sv
`timescale 1ns/1ps
module tsync_fifo #(
    parameter int unsigned NUM_TRIB = 4,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic [NUM_TRIB-1:0] trib_clk,
    input  logic                rst_n,
    input  logic [NUM_TRIB-1:0] trib_en,
    input  logic [NUM_TRIB-1:0] trib_bit,
    input  logic                frm_clk,
    input  logic [NUM_TRIB-1:0] stuff_opp,
    input  logic [NUM_TRIB-1:0] rd_en,
    output logic [NUM_TRIB-1:0] stuff_req,
    output logic [NUM_TRIB-1:0] dout,
    output logic [NUM_TRIB-1:0] dout_vld,
    output logic [NUM_TRIB-1:0] ovf_flag,
    output logic [NUM_TRIB-1:0] udf_flag
);
    localparam int unsigned PW    = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [NUM_TRIB*PW-1:0] occ_flat;

    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_lane
        logic [PW-1:0]    wr_gray, rd_gray;
        logic [DEPTH-1:0] mem;

        tsync_wr #(.AW(ADDR_W)) wr_i (
            .wclk      (trib_clk[g]),
            .rst_n     (rst_n),
            .we        (trib_en[g]),
            .wd        (trib_bit[g]),
            .rd_gray_i (rd_gray),
            .wr_gray_o (wr_gray),
            .mem_o     (mem)
        );

        tsync_rd #(.AW(ADDR_W)) rd_i (
            .rclk      (frm_clk),
            .rst_n     (rst_n),
            .stuff_opp (stuff_opp[g]),
            .rd_en     (rd_en[g]),
            .wr_gray_i (wr_gray),
            .mem_i     (mem),
            .rd_gray_o (rd_gray),
            .stuff_o   (stuff_req[g]),
            .dout_o    (dout[g]),
            .vld_o     (dout_vld[g]),
            .ovf_o     (ovf_flag[g]),
            .udf_o     (udf_flag[g]),
            .occ_o     (occ_flat[g*PW +: PW])
        );
    end
endmodule

// File: rtl/tsync_fifo_chk.sv
`timescale 1ns/1ps
module tsync_fifo_chk #(
    parameter int unsigned NUM_TRIB = 4,
    parameter int unsigned ADDR_W   = 4
) (
    input logic                            frm_clk,
    input logic                            rst_n,
    input logic [NUM_TRIB-1:0]             stuff_opp,
    input logic [NUM_TRIB-1:0]             rd_en,
    input logic [NUM_TRIB-1:0]             stuff_req,
    input logic [NUM_TRIB-1:0]             dout_vld,
    input logic [NUM_TRIB-1:0]             ovf_flag,
    input logic [NUM_TRIB-1:0]             udf_flag,
    input logic [NUM_TRIB*(ADDR_W+1)-1:0]  occ_flat
);
    localparam int unsigned PW    = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_chk
        logic [PW-1:0] occ;
        assign occ = occ_flat[g*PW +: PW];

        p_stuff_low_r2: assert property (@(posedge frm_clk) disable iff (!rst_n)
            (stuff_opp[g] && occ < HALF_LVL) |=> (stuff_req[g] && !dout_vld[g]));

        p_take_high_r2: assert property (@(posedge frm_clk) disable iff (!rst_n)
            (stuff_opp[g] && occ >= HALF_LVL && occ != FULL_LVL) |=> (!stuff_req[g] && dout_vld[g]));

        p_no_strobe_no_data_r3: assert property (@(posedge frm_clk) disable iff (!rst_n)
            (!stuff_opp[g] && !rd_en[g]) |=> !dout_vld[g]);

        p_udf_recentre_r4: assert property (@(posedge frm_clk) disable iff (!rst_n)
            $rose(udf_flag[g]) |-> (occ >= HALF_LVL));

        p_ovf_recentre_r5: assert property (@(posedge frm_clk) disable iff (!rst_n)
            $rose(ovf_flag[g]) |-> (occ >= HALF_LVL));

        p_occ_bound_r5: assert property (@(posedge frm_clk) disable iff (!rst_n)
            occ <= FULL_LVL);

        p_ovf_sticky_r9: assert property (@(posedge frm_clk) disable iff (!rst_n)
            ovf_flag[g] |=> ovf_flag[g]);

        p_udf_sticky_r9: assert property (@(posedge frm_clk) disable iff (!rst_n)
            udf_flag[g] |=> udf_flag[g]);
    end
endmodule

bind tsync_fifo tsync_fifo_chk #(
    .NUM_TRIB (NUM_TRIB),
    .ADDR_W   (ADDR_W)
) chk_i (
    .frm_clk   (frm_clk),
    .rst_n     (rst_n),
    .stuff_opp (stuff_opp),
    .rd_en     (rd_en),
    .stuff_req (stuff_req),
    .dout_vld  (dout_vld),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag),
    .occ_flat  (occ_flat)
);

// File: tb/tsync_fifo_tb_top.sv
`timescale 1ns/1ps
module tsync_fifo_tb_top;
    localparam int N = 4;

    logic       rclk = 1'b0;
    logic       wclk0 = 1'b0, wclk1 = 1'b0, wclk2 = 1'b0, wclk3 = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] trib_en = '0, trib_bit = '0, stuff_opp = '0, rd_en = '0;
    logic [N-1:0] stuff_req, dout, dout_vld, ovf_flag, udf_flag;
    logic [N-1:0] trib_clk;

    int nchk = 0, nerr = 0;
    bit mon_on = 1'b0;
    int mon_reads = 0, mon_bad = 0;
    bit exp_q[$];

    assign trib_clk = {wclk3, wclk2, wclk1, wclk0};

    always #2.5 rclk  = ~rclk;
    always #5.0 wclk0 = ~wclk0;
    always #5.0 wclk1 = ~wclk1;
    always #5.0 wclk2 = ~wclk2;
    always #5.1 wclk3 = ~wclk3;

    tsync_fifo #(.NUM_TRIB(N), .ADDR_W(4)) dut_i (
        .trib_clk  (trib_clk),
        .rst_n     (rst_n),
        .trib_en   (trib_en),
        .trib_bit  (trib_bit),
        .frm_clk   (rclk),
        .stuff_opp (stuff_opp),
        .rd_en     (rd_en),
        .stuff_req (stuff_req),
        .dout      (dout),
        .dout_vld  (dout_vld),
        .ovf_flag  (ovf_flag),
        .udf_flag  (udf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wneg(input int l);
        case (l)
            0: @(negedge wclk0);
            1: @(negedge wclk1);
            2: @(negedge wclk2);
            default: @(negedge wclk3);
        endcase
    endtask

    task automatic wr_bits(input int l, input int first, input int n, input logic [15:0] pat);
        for (int i = 0; i < n; i++) begin
            wneg(l);
            trib_en[l]  = 1'b1;
            trib_bit[l] = pat[first+i];
        end
        wneg(l);
        trib_en[l]  = 1'b0;
        trib_bit[l] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge rclk);
    endtask

    // One strobe cycle; outputs are sampled one frame clock later
    task automatic strobe(input int l, input bit opp, input bit rd,
                          output bit st, output bit v, output bit d);
        @(negedge rclk);
        stuff_opp[l] = opp;
        rd_en[l]     = rd;
        @(negedge rclk);
        stuff_opp[l] = 1'b0;
        rd_en[l]     = 1'b0;
        st = stuff_req[l];
        v  = dout_vld[l];
        d  = dout[l];
    endtask

    task automatic t_reset();
        idle(2);
        chk("R8 stuff_req", int'(stuff_req), 0);
        chk("R8 dout_vld", int'(dout_vld), 0);
        chk("R8 dout", int'(dout), 0);
        chk("R8 ovf_flag", int'(ovf_flag), 0);
        chk("R8 udf_flag", int'(udf_flag), 0);
    endtask

    task automatic t_prime_and_underflow();
        logic [15:0] pat = 16'b0000_0101_1001_0110;
        bit st, v, d;
        strobe(0, 1, 0, st, v, d);
        chk("R3 stuff before priming", st, 1);
        chk("R3 no data at early opportunity", v, 0);
        wr_bits(0, 0, 5, pat);
        idle(8);
        strobe(0, 1, 0, st, v, d);
        chk("R3 stuff at occupancy 5", st, 1);
        strobe(0, 0, 1, st, v, d);
        chk("R3 read ignored before priming", v, 0);
        wr_bits(0, 5, 5, pat);
        idle(8);
        strobe(0, 1, 0, st, v, d);
        chk("R2 no stuff at occupancy 10", st, 0);
        chk("R2 data valid at opportunity", v, 1);
        chk("R1 bit 0", d, pat[0]);
        for (int i = 1; i < 3; i++) begin
            strobe(0, 0, 1, st, v, d);
            chk("R1 valid", v, 1);
            chk("R1 order", d, pat[i]);
        end
        strobe(0, 1, 0, st, v, d);
        chk("R2 stuff at occupancy 7", st, 1);
        chk("R2 nothing read at occupancy 7", v, 0);
        wr_bits(0, 10, 1, pat);
        idle(8);
        strobe(0, 1, 0, st, v, d);
        chk("R2 no stuff at occupancy 8", st, 0);
        chk("R2 bit 3 at occupancy 8", d, pat[3]);
        for (int i = 4; i < 11; i++) begin
            strobe(0, 0, 1, st, v, d);
            chk("R1 order", d, pat[i]);
        end
        chk("R4 no flag before empty read", udf_flag[0], 0);
        strobe(0, 0, 1, st, v, d);
        chk("R4 empty read not valid", v, 0);
        chk("R4 underflow flag", udf_flag[0], 1);
        strobe(0, 1, 0, st, v, d);
        chk("R4 recentred to 8, no stuff", st, 0);
        chk("R4 recentred data valid", v, 1);
        idle(10);
        chk("R9 underflow sticky", udf_flag[0], 1);
        chk("R6 lane0 no overflow", ovf_flag[0], 0);
    endtask

    task automatic t_overflow();
        logic [15:0] pat = 16'hC5A3;
        bit st, v, d;
        wr_bits(1, 0, 16, pat);
        idle(10);
        chk("R5 overflow flag", ovf_flag[1], 1);
        chk("R5 no underflow", udf_flag[1], 0);
        for (int i = 0; i < 8; i++) begin
            strobe(1, 0, 1, st, v, d);
            chk("R5 newest 8 kept valid", v, 1);
            chk("R5 newest 8 kept", d, pat[8+i]);
        end
        strobe(1, 1, 0, st, v, d);
        chk("R5 empty after 8, stuff", st, 1);
        idle(10);
        chk("R9 overflow sticky", ovf_flag[1], 1);
        chk("R6 lane0 ovf untouched", ovf_flag[0], 0);
        chk("R6 lane2 flags", int'({ovf_flag[2], udf_flag[2]}), 0);
        chk("R6 lane2 outputs", int'({stuff_req[2], dout_vld[2]}), 0);
    endtask

    task automatic t_stream();
        int stuffs = 0;
        mon_on = 1'b1;
        fork
            begin : writer
                logic [6:0] lfsr = 7'h5B;
                for (int i = 0; i < 400; i++) begin
                    wneg(3);
                    trib_en[3]  = 1'b1;
                    trib_bit[3] = lfsr[0];
                    exp_q.push_back(lfsr[0]);
                    lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
                end
                wneg(3);
                trib_en[3] = 1'b0;
            end
            begin : reader
                for (int f = 0; f < 70; f++) begin
                    for (int c = 0; c < 10; c++) begin
                        @(negedge rclk);
                        if (c == 1 && stuff_req[3] && mon_reads > 0) stuffs++;
                        stuff_opp[3] = (c == 0);
                        rd_en[3]     = (c != 0) && (c % 2 == 0);
                    end
                end
                @(negedge rclk);
                stuff_opp[3] = 1'b0;
                rd_en[3]     = 1'b0;
                @(negedge rclk);
                mon_on = 1'b0;
                chk("R7 no overflow", ovf_flag[3], 0);
                chk("R7 no underflow", udf_flag[3], 0);
                chk("R1 stream mismatches", mon_bad, 0);
                chk("R7 bits delivered >= 300", int'(mon_reads >= 300), 1);
                chk("R7 stuff requested", int'(stuffs >= 1), 1);
            end
        join
    endtask

    // Lane 3 data monitor for the continuous test
    initial begin
        forever begin
            @(negedge rclk);
            if (mon_on && dout_vld[3]) begin
                mon_reads++;
                if (exp_q.size() == 0) mon_bad++;
                else if (exp_q.pop_front() != dout[3]) mon_bad++;
            end
        end
    end

    initial begin
        #500000;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rclk);
        rst_n = 1'b1;
        t_reset();
        t_prime_and_underflow();
        t_overflow();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule